// File: doc/BRIEF.md
# I2C Bus Master Transmit Controller

This block is the sending side of an I2C bus master. Software sets a clock-select field, a frame length, a bit order and whether an acknowledge clock is wanted. It then asks for a START, and after that writes one byte at a time. The controller produces the START, shifts each byte onto SDA with one SCL pulse per bit, and optionally adds a ninth clock in which the receiver may pull SDA low. It records the sampled acknowledge and raises a frame-done flag. It keeps SCL low until software clears the flag. A STOP request then returns the bus to idle.

The pads are open-drain, and each is modelled as a pair: an output enable that pulls the line low, and an input that reads the line. Only SDA is read back. SCL is never stretched by a slave in this model.

The controller is built around one state machine with eleven named states:
- `S_IDLE`: the bus is released.
- `S_START_SDA`: SDA is pulled low while SCL stays high.
- `S_START_SCL`: SCL is pulled low.
- `S_WAIT`: SCL is held low and SDA is released. The machine waits for a byte or a stop.
- `S_BIT_LOW`: SCL is low and the data bit is placed on SDA.
- `S_BIT_HIGH`: SCL is released with the data bit still on SDA.
- `S_ACK_LOW`: SCL is low and SDA is released.
- `S_ACK_HIGH`: SCL is released and SDA is sampled.
- `S_STOP_LOW`: SCL and SDA are both low.
- `S_STOP_HIGH`: SCL is released and SDA stays low.
- `S_STOP_DONE`: SDA is released while SCL is high.

The transitions are as follows:
- IDLE→START_SDA on `start_req`.
- START_SDA→START_SCL→WAIT on successive half-period ticks.
- WAIT→BIT_LOW on an accepted byte write.
- WAIT→STOP_LOW on an accepted stop request.
- BIT_LOW→BIT_HIGH on a tick.
- BIT_HIGH→BIT_LOW on a tick while bits remain.
- BIT_HIGH→ACK_LOW on a tick after the last bit, when the acknowledge clock is enabled.
- BIT_HIGH→WAIT on a tick after the last bit, when the acknowledge clock is suppressed.
- ACK_LOW→ACK_HIGH→WAIT on ticks.
- STOP_LOW→STOP_HIGH→STOP_DONE→IDLE on ticks.

Top module: `i2c_tx_master`

## Requirements
- R1: After reset, `scl_oe` and `sda_oe` are 0 (both lines released), and `bus_busy`, `frame_done` and `irq` are 0. No bus activity occurs until `start_req` is seen.
- R2: A `start_req` pulse in idle sets `bus_busy`. SDA then goes low while SCL is high (a START), and half a period later SCL goes low and is held there.
- R3: An accepted frame carries N data bits, where N equals `cfg_bit_count` (the value 0 means 8). Each bit gets one SCL pulse. When `cfg_lsb_first` is 0 the bits go out as data_in[7], data_in[6], and so on down; when it is 1 they go out as data_in[0], data_in[1], and so on up. SDA never changes while SCL is high, except at START and STOP.
- R4: When `cfg_no_ack` is 0, a further clock follows the data bits with SDA released. The SDA level sampled at the end of that clock's high half is stored in `ack_miss`: 0 means acknowledged, 1 means not acknowledged.
- R5: When `cfg_no_ack` is 1, no acknowledge clock is produced, so the frame has exactly N SCL pulses.
- R6: `frame_done` sets in the same cycle that SCL is released for the frame's final clock. That final clock is the acknowledge clock, or the last data clock when acknowledge is suppressed. `irq` equals `frame_done` gated by `cfg_irq_en`.
- R7: After a frame, SCL goes low at the end of the final clock and stays low while `frame_done` is 1. `frame_done` stays 1 until a `flag_clr` pulse.
- R8: Each SCL half period lasts (BASE_DIV << `cfg_clk_sel`) / 2 system clocks. With the default BASE_DIV=16, that gives full periods of 16, 32, ..., 2048 clocks.
- R9: A `data_wr` is ignored while a frame is shifting, while `frame_done` is 1, and in idle. The bits sent and the bus stay as they would have been without it.
- R10: A `stop_req` pulse in the wait state with `frame_done` clear pulls SDA low, releases SCL, and then releases SDA while SCL is high (a STOP). `bus_busy` clears and the block returns to idle with both lines released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_clk_sel | input | SEL_W (3) | SCL rate select; the period is BASE_DIV << value |
| cfg_bit_count | input | $clog2(DATA_W) (3) | Data bits per frame; 0 means DATA_W |
| cfg_lsb_first | input | 1 | 1: least significant bit first; 0: most significant bit first |
| cfg_no_ack | input | 1 | 1: suppress the acknowledge clock |
| cfg_irq_en | input | 1 | Interrupt request enable |
| start_req | input | 1 | One-cycle request for a START |
| stop_req | input | 1 | One-cycle request for a STOP |
| data_wr | input | 1 | One-cycle data register write |
| data_in | input | DATA_W (8) | Byte to transmit |
| flag_clr | input | 1 | One-cycle clear of `frame_done` |
| sda_in | input | 1 | Sensed SDA level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| bus_busy | output | 1 | Set from START until STOP completes |
| frame_done | output | 1 | Frame-complete flag |
| irq | output | 1 | Interrupt request |
| ack_miss | output | 1 | Last acknowledge: 1 means not acknowledged |

## Verification
The assertions assume that the configuration inputs only change while the bus is idle or held in the wait state. The half-period counter bound and the frame length both depend on those inputs holding steady through a frame. They also assume that request pulses last one cycle.

The bench changes configuration only between frames, before it writes the next byte, and drives every request for exactly one cycle at a falling clock edge. Its slave model pulls SDA low only inside the acknowledge clock's low and high halves, so the rule that SDA stays stable while SCL is high is checked only against the master's own drive.

// File: rtl/i2c_txm_pkg.sv
package i2c_txm_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_START_SDA,
        S_START_SCL,
        S_WAIT,
        S_BIT_LOW,
        S_BIT_HIGH,
        S_ACK_LOW,
        S_ACK_HIGH,
        S_STOP_LOW,
        S_STOP_HIGH,
        S_STOP_DONE
    } txm_state_e;

endpackage

// File: rtl/i2c_txm_tick.sv
module i2c_txm_tick #(
    parameter int BASE_DIV = 16,
    parameter int SEL_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int HALF_BASE = BASE_DIV / 2;
    localparam int SEL_MAX   = (1 << SEL_W) - 1;
    localparam int MAX_HALF  = HALF_BASE << SEL_MAX;
    localparam int CNT_W     = $clog2(MAX_HALF + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half_m1;

    always_comb begin
        half_m1 = CNT_W'((HALF_BASE << sel) - 1);
        tick    = run && (cnt == half_m1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // R8
    half_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= half_m1));

endmodule

// File: rtl/i2c_txm_fsm.sv
module i2c_txm_fsm
    import i2c_txm_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start_req,
    input  logic              stop_req,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_in,
    input  logic [CNT_W-1:0]  cfg_bit_count,
    input  logic              cfg_lsb_first,
    input  logic              cfg_no_ack,
    input  logic              cfg_irq_en,
    input  logic              flag_clr,
    input  logic              sda_in,
    output logic              run,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              busy,
    output logic              flag,
    output logic              irq,
    output logic              nack
);
    txm_state_e        state, state_nx;
    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  bits_left;
    logic              lsb_q, noack_q;
    logic              cur_bit, take_byte, take_stop, last_bit, flag_set;

    always_comb begin
        cur_bit   = lsb_q ? shreg[0] : shreg[DATA_W-1];
        take_byte = (state == S_WAIT) && !flag && data_wr;
        take_stop = (state == S_WAIT) && !flag && stop_req && !data_wr;
        last_bit  = (bits_left == '0);
        flag_set  = tick && (((state == S_BIT_LOW) && last_bit && noack_q) ||
                             (state == S_ACK_LOW));
        run       = (state != S_IDLE) && (state != S_WAIT);
        irq       = flag && cfg_irq_en;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:      if (start_req) state_nx = S_START_SDA;
            S_START_SDA: if (tick) state_nx = S_START_SCL;
            S_START_SCL: if (tick) state_nx = S_WAIT;
            S_WAIT: begin
                if (take_byte)      state_nx = S_BIT_LOW;
                else if (take_stop) state_nx = S_STOP_LOW;
            end
            S_BIT_LOW:   if (tick) state_nx = S_BIT_HIGH;
            S_BIT_HIGH: begin
                if (tick) begin
                    if (!last_bit)    state_nx = S_BIT_LOW;
                    else if (noack_q) state_nx = S_WAIT;
                    else              state_nx = S_ACK_LOW;
                end
            end
            S_ACK_LOW:   if (tick) state_nx = S_ACK_HIGH;
            S_ACK_HIGH:  if (tick) state_nx = S_WAIT;
            S_STOP_LOW:  if (tick) state_nx = S_STOP_HIGH;
            S_STOP_HIGH: if (tick) state_nx = S_STOP_DONE;
            S_STOP_DONE: if (tick) state_nx = S_IDLE;
            default:     state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // line outputs
    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        unique case (state)
            S_IDLE:      begin scl_oe = 1'b0; sda_oe = 1'b0;     end
            S_START_SDA: begin scl_oe = 1'b0; sda_oe = 1'b1;     end
            S_START_SCL: begin scl_oe = 1'b1; sda_oe = 1'b1;     end
            S_WAIT:      begin scl_oe = 1'b1; sda_oe = 1'b0;     end
            S_BIT_LOW:   begin scl_oe = 1'b1; sda_oe = !cur_bit; end
            S_BIT_HIGH:  begin scl_oe = 1'b0; sda_oe = !cur_bit; end
            S_ACK_LOW:   begin scl_oe = 1'b1; sda_oe = 1'b0;     end
            S_ACK_HIGH:  begin scl_oe = 1'b0; sda_oe = 1'b0;     end
            S_STOP_LOW:  begin scl_oe = 1'b1; sda_oe = 1'b1;     end
            S_STOP_HIGH: begin scl_oe = 1'b0; sda_oe = 1'b1;     end
            S_STOP_DONE: begin scl_oe = 1'b0; sda_oe = 1'b0;     end
            default:     begin scl_oe = 1'b0; sda_oe = 1'b0;     end
        endcase
    end

    // datapath and status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            bits_left <= '0;
            lsb_q     <= 1'b0;
            noack_q   <= 1'b0;
            busy      <= 1'b0;
            flag      <= 1'b0;
            nack      <= 1'b0;
        end else begin
            if (take_byte) begin
                shreg     <= data_in;
                bits_left <= (cfg_bit_count == '0) ? CNT_W'(DATA_W - 1)
                                                   : cfg_bit_count - 1'b1;
                lsb_q     <= cfg_lsb_first;
                noack_q   <= cfg_no_ack;
            end else if ((state == S_BIT_HIGH) && tick && !last_bit) begin
                shreg     <= lsb_q ? (shreg >> 1) : (shreg << 1);
                bits_left <= bits_left - 1'b1;
            end
            if ((state == S_IDLE) && start_req)
                busy <= 1'b1;
            else if ((state == S_STOP_DONE) && tick)
                busy <= 1'b0;
            if (flag_set)
                flag <= 1'b1;
            else if (flag_clr)
                flag <= 1'b0;
            if ((state == S_ACK_HIGH) && tick)
                nack <= sda_in;
        end
    end

    // R3
    sda_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe))) |->
        ((state == S_START_SDA && sda_oe) || (state == S_STOP_DONE && !sda_oe)));

    // R6
    flag_at_scl_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> (!scl_oe && $past(scl_oe)));

    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);

    // R7
    scl_rise_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(scl_oe) && !scl_oe) |-> !$past(flag));

    // R10
    busy_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy == (state != S_IDLE));

    // R9
    ignore_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && data_wr && !((state == S_BIT_HIGH) && tick)) |=> (shreg == $past(shreg)));

endmodule

// File: rtl/i2c_tx_master.sv
module i2c_tx_master #(
    parameter int DATA_W   = 8,
    parameter int SEL_W    = 3,
    parameter int BASE_DIV = 16,
    localparam int CNT_W   = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  cfg_clk_sel,
    input  logic [CNT_W-1:0]  cfg_bit_count,
    input  logic              cfg_lsb_first,
    input  logic              cfg_no_ack,
    input  logic              cfg_irq_en,
    input  logic              start_req,
    input  logic              stop_req,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_in,
    input  logic              flag_clr,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              bus_busy,
    output logic              frame_done,
    output logic              irq,
    output logic              ack_miss
);
    logic run, tick;

    i2c_txm_tick #(
        .BASE_DIV (BASE_DIV),
        .SEL_W    (SEL_W)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .sel   (cfg_clk_sel),
        .tick  (tick)
    );

    i2c_txm_fsm #(
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .start_req     (start_req),
        .stop_req      (stop_req),
        .data_wr       (data_wr),
        .data_in       (data_in),
        .cfg_bit_count (cfg_bit_count),
        .cfg_lsb_first (cfg_lsb_first),
        .cfg_no_ack    (cfg_no_ack),
        .cfg_irq_en    (cfg_irq_en),
        .flag_clr      (flag_clr),
        .sda_in        (sda_in),
        .run           (run),
        .scl_oe        (scl_oe),
        .sda_oe        (sda_oe),
        .busy          (bus_busy),
        .flag          (frame_done),
        .irq           (irq),
        .nack          (ack_miss)
    );

endmodule

// File: tb/i2c_tx_master_bench.sv
module i2c_tx_master_bench;
    localparam int DATA_W   = 8;
    localparam int SEL_W    = 3;
    localparam int BASE_DIV = 16;
    localparam int CNT_W    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [SEL_W-1:0]  cfg_clk_sel = '0;
    logic [CNT_W-1:0]  cfg_bit_count = '0;
    logic              cfg_lsb_first = 1'b0;
    logic              cfg_no_ack = 1'b0;
    logic              cfg_irq_en = 1'b1;
    logic              start_req = 1'b0;
    logic              stop_req = 1'b0;
    logic              data_wr = 1'b0;
    logic [DATA_W-1:0] data_in = '0;
    logic              flag_clr = 1'b0;
    logic              sda_in;
    logic              scl_oe, sda_oe, bus_busy, frame_done, irq, ack_miss;
    logic              slave_pull = 1'b0;

    assign sda_in = !(sda_oe || slave_pull);

    i2c_tx_master #(
        .DATA_W   (DATA_W),
        .SEL_W    (SEL_W),
        .BASE_DIV (BASE_DIV)
    ) u_i2c_tx_master (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_clk_sel   (cfg_clk_sel),
        .cfg_bit_count (cfg_bit_count),
        .cfg_lsb_first (cfg_lsb_first),
        .cfg_no_ack    (cfg_no_ack),
        .cfg_irq_en    (cfg_irq_en),
        .start_req     (start_req),
        .stop_req      (stop_req),
        .data_wr       (data_wr),
        .data_in       (data_in),
        .flag_clr      (flag_clr),
        .sda_in        (sda_in),
        .scl_oe        (scl_oe),
        .sda_oe        (sda_oe),
        .bus_busy      (bus_busy),
        .frame_done    (frame_done),
        .irq           (irq),
        .ack_miss      (ack_miss)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // bus monitor and slave model
    logic        prev_scl = 1'b1, prev_sda = 1'b1;
    int          start_seen = 0, stop_seen = 0;
    int          rise_idx = 0, frame_id = 0, seen_id = 0;
    int          high_run = 0, last_high = 0, exp_bits = 8;
    logic        slave_ack = 1'b0;
    logic [15:0] cap = '0;

    always @(negedge clk) begin
        logic scl_line;
        scl_line = !scl_oe;
        if (seen_id != frame_id) begin
            seen_id  = frame_id;
            rise_idx = 0;
            cap      = '0;
        end
        if (scl_line && prev_scl && prev_sda && !sda_in) start_seen++;
        if (scl_line && prev_scl && !prev_sda && sda_in) stop_seen++;
        if (scl_line && !prev_scl) begin
            if (rise_idx < 16) cap[rise_idx] = sda_in;
            rise_idx++;
            high_run = 1;
        end else if (scl_line) begin
            high_run++;
        end
        if (!scl_line && prev_scl) begin
            last_high = high_run;
            slave_pull <= (rise_idx == exp_bits) && slave_ack;
        end
        prev_scl = scl_line;
        prev_sda = sda_in;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int half_cycles(input int sel);
        return (BASE_DIV << sel) / 2;
    endfunction

    task automatic wait_flag(input string req);
        int t = 0;
        while (!(frame_done && scl_oe) && t < 40000) begin
            @(negedge clk);
            t++;
        end
        check(t < 40000, req, "frame_done timeout", t, 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic run_frame(input logic [7:0] d, input int bitsf, input bit lsb,
                             input bit noack, input bit ack, input bit ien,
                             input bit inject);
        int n, exp_v, got_v, rises, h;
        n = (bitsf == 0) ? 8 : bitsf;
        h = half_cycles(int'(cfg_clk_sel));
        @(negedge clk);
        cfg_bit_count = CNT_W'(bitsf);
        cfg_lsb_first = lsb;
        cfg_no_ack    = noack;
        cfg_irq_en    = ien;
        exp_bits      = n;
        slave_ack     = ack && !noack;
        frame_id++;
        @(negedge clk);
        data_in = d;
        data_wr = 1'b1;
        @(negedge clk);
        data_wr = 1'b0;
        data_in = ~d;
        if (inject) begin
            // R9: a write during shifting must not alter the bits sent
            repeat (h + 2) @(negedge clk);
            data_wr = 1'b1;
            @(negedge clk);
            data_wr = 1'b0;
        end
        wait_flag("R6");
        exp_v = 0;
        got_v = 0;
        for (int i = 0; i < n; i++) begin
            exp_v[i] = lsb ? d[i] : d[7-i];
            got_v[i] = cap[i];
        end
        check(got_v == exp_v, inject ? "R9" : "R3", "data bits", got_v, exp_v);
        rises = rise_idx;
        check(rises == n + (noack ? 0 : 1), noack ? "R5" : "R4", "SCL pulses",
              rises, n + (noack ? 0 : 1));
        if (!noack)
            check(ack_miss == !ack, "R4", "ack_miss", int'(ack_miss), int'(!ack));
        check(last_high == h, "R8", "SCL high width", last_high, h);
        check(irq == ien, "R6", "irq", int'(irq), int'(ien));
        if (inject) begin
            // R9: a write while frame_done is set is ignored
            data_in = d;
            data_wr = 1'b1;
            @(negedge clk);
            data_wr = 1'b0;
        end
        repeat (3 * h) @(negedge clk);
        check(scl_oe && frame_done && rise_idx == rises, "R7", "SCL held low",
              rise_idx, rises);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        @(negedge clk);
        check(!frame_done, "R7", "flag cleared", int'(frame_done), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1 reset state
        check(!scl_oe && !sda_oe, "R1", "lines released", int'({scl_oe, sda_oe}), 0);
        check(!bus_busy && !frame_done && !irq, "R1", "status",
              int'({bus_busy, frame_done, irq}), 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check(start_seen == 0 && !scl_oe, "R1", "no activity", start_seen, 0);

        // R2 start condition
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        repeat (3 * half_cycles(0)) @(negedge clk);
        check(start_seen == 1, "R2", "START seen", start_seen, 1);
        check(bus_busy && scl_oe, "R2", "busy and SCL low", int'({bus_busy, scl_oe}), 3);

        // R3/R4/R5 sweep of frame length, order and acknowledge handling
        for (int k = 0; k < 16; k++) begin
            run_frame(8'(8'h5A ^ (k * 29)), k % 8, k >= 8, (k % 3) == 2,
                      (k % 5) != 1, (k % 4) != 3, (k % 4) == 1);
        end

        // R8 divider sweep with one-bit frames
        for (int s = 0; s < 8; s++) begin
            cfg_clk_sel = SEL_W'(s);
            run_frame(8'h80, 1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        end
        cfg_clk_sel = SEL_W'(2);
        run_frame(8'hC3, 0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        cfg_clk_sel = '0;

        // R10 stop condition
        @(negedge clk);
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        begin
            int t = 0;
            while (bus_busy && t < 1000) begin
                @(negedge clk);
                t++;
            end
        end
        repeat (2) @(negedge clk);
        check(stop_seen == 1, "R10", "STOP seen", stop_seen, 1);
        check(!bus_busy && !scl_oe && !sda_oe, "R10", "idle after stop",
              int'({bus_busy, scl_oe, sda_oe}), 0);

        // R9 write in idle ignored
        frame_id++;
        @(negedge clk);
        data_wr = 1'b1;
        @(negedge clk);
        data_wr = 1'b0;
        repeat (50) @(negedge clk);
        check(rise_idx == 0 && !bus_busy, "R9", "idle write ignored", rise_idx, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule